// File: doc/BRIEF.md
# Isochronous Resource Register File

This block keeps the four shared registers through which nodes on a serial bus claim isochronous resources. The registers are the identity of the node acting as bus manager (6 bits), the isochronous bandwidth still free (13 bits, in time units), and two 32-bit masks that hold one bit per channel for 64 channels. A set bit in a mask means that channel is free.

Requests come in on one port. A request names a register with a 2-bit select and is either a plain quadlet read or a compare-and-swap. A compare-and-swap writes its new value only if the register currently equals the compare value. Both kinds of request return the value the register held before the request. That lets a requester that loses a race retry with the value it was given. The response comes one cycle after the request is accepted. A pulse on the bus-reset input puts all four registers back to their power-on values.

Top module: `iso_res_regs`

## Requirements
- R1: After `rst`, the manager register reads 0x3F, bandwidth reads 4915 (0x1333), and both channel masks read 0xFFFFFFFF.
- R2: `req_sel` selects the register: 0 is the manager ID, 1 is bandwidth, 2 is the mask for channels 0 to 31, and 3 is the mask for channels 32 to 63. `req_op` 0 is a read and 1 is a compare-and-swap.
- R3: A read returns the selected register zero-extended to 32 bits, with `rsp_swapped` low, and leaves every register unchanged.
- R4: A compare-and-swap whose compare value matches the register loads the new value, returns the prior value and raises `rsp_swapped`.
- R5: A compare-and-swap that does not match leaves the register unchanged, returns its current value and holds `rsp_swapped` low.
- R6: Bits of `req_cmp` and `req_new` above the width of the selected register are ignored, both in the comparison and in the stored value.
- R7: Each accepted request gives exactly one response, with `rsp_valid` high in the cycle after acceptance. When no request was accepted in the previous cycle, `rsp_valid` is low.
- R8: While `bus_reset` is high, `req_ready` is low and no request is accepted. In the cycle after `bus_reset`, all four registers hold their R1 values.
- R9: When two back-to-back compare-and-swaps to one register carry the same compare value, only the first one swaps.
- R10: Registers that are not selected keep their values across a compare-and-swap to another register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Restores the power-on values of all registers |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_op | input | 1 | 0 for a read, 1 for a compare-and-swap |
| req_sel | input | 2 | Register select |
| req_cmp | input | 32 | Compare value |
| req_new | input | 32 | Value written when the compare matches |
| rsp_valid | output | 1 | Response present |
| rsp_old | output | 32 | Register value before the request, zero-extended |
| rsp_swapped | output | 1 | The compare-and-swap stored its new value |

## Verification
The assertions check on every cycle the following properties. Each register is held unless a matching swap or a bus reset touches it. A matching swap stores exactly the masked new value. A bus reset returns each register to its power-on value. A response follows exactly one cycle after each acceptance, and the manager response never carries bits above bit 5. Only the bench's scenarios can show the concrete values a requester sees: the power-on contents, the masking of wide compare values, and the register independence seen through reads. The same holds for a second swap that loses after the first one wins, and for a request refused during a bus reset.

// File: rtl/irr_pkg.sv
package irr_pkg;
    localparam int WORD_W = 32;
    localparam int NREG   = 4;

    typedef enum logic [1:0] {
        SEL_MGR = 2'd0,
        SEL_BW  = 2'd1,
        SEL_CHA = 2'd2,
        SEL_CHB = 2'd3
    } rsel_e;

    typedef enum logic {
        OP_READ = 1'b0,
        OP_CAS  = 1'b1
    } rop_e;

    typedef struct packed {
        rop_e              op;
        rsel_e             sel;
        logic [WORD_W-1:0] cmp;
        logic [WORD_W-1:0] nd;
    } req_t;

    typedef struct packed {
        logic              valid;
        logic              swapped;
        logic [WORD_W-1:0] old;
    } rsp_t;
endpackage

// File: rtl/irr_field.sv
module irr_field
    import irr_pkg::*;
#(
    parameter int              W   = 13,
    parameter logic [W-1:0]    RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] cmp_in,
    input  logic [WORD_W-1:0] new_in,
    output logic [WORD_W-1:0] val_out,
    output logic              match
);
    logic [W-1:0] q;

    assign match   = (cmp_in[W-1:0] == q);
    assign val_out = WORD_W'(q);

    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= RST;
        else if (wr_en && match)
            q <= new_in[W-1:0];
    end

    // R5 / R10: no matching swap and no bus reset means the field holds
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!clr && !(wr_en && match)) |=> $stable(q));

    // R4 / R6: a matching swap stores the masked new value
    assert_swap_R4: assert property (@(posedge clk) disable iff (rst)
        (!clr && wr_en && match) |=> (q == $past(new_in[W-1:0])));

    // R8: bus reset restores the power-on value
    assert_clr_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == RST));
endmodule

// File: rtl/irr_resp.sv
module irr_resp
    import irr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              is_cas,
    input  logic              hit,
    input  logic [WORD_W-1:0] cur_val,
    output rsp_t              rsp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp.valid   <= accept;
            rsp.swapped <= accept && is_cas && hit;
            rsp.old     <= accept ? cur_val : rsp.old;
        end
    end
endmodule

// File: rtl/iso_res_regs.sv
module iso_res_regs
    import irr_pkg::*;
#(
    parameter int          MGR_W    = 6,
    parameter int          BW_W     = 13,
    parameter int          CH_W     = 32,
    parameter int unsigned BW_RESET = 4915
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_reset,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_op,
    input  logic [1:0]  req_sel,
    input  logic [31:0] req_cmp,
    input  logic [31:0] req_new,
    output logic        rsp_valid,
    output logic [31:0] rsp_old,
    output logic        rsp_swapped
);
    req_t              req;
    rsp_t              rsp;
    logic              accept;
    logic [WORD_W-1:0] fld_val [NREG];
    logic [NREG-1:0]   fld_match;
    logic [NREG-1:0]   fld_wr;

    assign req.op  = rop_e'(req_op);
    assign req.sel = rsel_e'(req_sel);
    assign req.cmp = req_cmp;
    assign req.nd  = req_new;

    assign req_ready = !rst && !bus_reset;
    assign accept    = req_valid && req_ready;

    for (genvar i = 0; i < NREG; i++) begin : g_fld
        localparam int FW = (i == 0) ? MGR_W : (i == 1) ? BW_W : CH_W;
        localparam logic [FW-1:0] FRST =
            (i == 0) ? {FW{1'b1}} :
            (i == 1) ? FW'(BW_RESET) : {FW{1'b1}};

        assign fld_wr[i] = accept && (req.op == OP_CAS) && (req.sel == rsel_e'(i));

        irr_field #(.W(FW), .RST(FRST)) u_fld (
            .clk     (clk),
            .rst     (rst),
            .clr     (bus_reset),
            .wr_en   (fld_wr[i]),
            .cmp_in  (req.cmp),
            .new_in  (req.nd),
            .val_out (fld_val[i]),
            .match   (fld_match[i])
        );
    end

    irr_resp u_resp (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .is_cas  (req.op == OP_CAS),
        .hit     (fld_match[req.sel]),
        .cur_val (fld_val[req.sel]),
        .rsp     (rsp)
    );

    assign rsp_valid   = rsp.valid;
    assign rsp_old     = rsp.old;
    assign rsp_swapped = rsp.swapped;

    // R7: a response follows each acceptance by exactly one cycle
    assert_rsp_follows_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !rsp_valid);

    // R3: a manager response carries no bits above the field width
    assert_mgr_zext_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_sel) == SEL_MGR) |-> (rsp_old[31:MGR_W] == '0));

    // R3: a read never reports a swap
    assert_read_noswap_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_op) |=> !rsp_swapped);
endmodule

// File: tb/tb_iso_res_regs.sv
module tb_iso_res_regs;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_reset;
    logic        req_valid;
    logic        req_ready;
    logic        req_op;
    logic [1:0]  req_sel;
    logic [31:0] req_cmp;
    logic [31:0] req_new;
    logic        rsp_valid;
    logic [31:0] rsp_old;
    logic        rsp_swapped;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    iso_res_regs dut (
        .clk(clk), .rst(rst), .bus_reset(bus_reset),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_sel(req_sel),
        .req_cmp(req_cmp), .req_new(req_new),
        .rsp_valid(rsp_valid), .rsp_old(rsp_old), .rsp_swapped(rsp_swapped)
    );

    typedef struct packed {
        logic        op;
        logic [1:0]  sel;
        logic [31:0] cmp;
        logic [31:0] nd;
        logic [31:0] exp_old;
        logic        exp_sw;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd0, 32'h0,        32'h0,        32'h0000003F, 1'b0}, // R1 manager
        '{1'b0, 2'd1, 32'h0,        32'h0,        32'h00001333, 1'b0}, // R1 bandwidth
        '{1'b0, 2'd2, 32'h0,        32'h0,        32'hFFFFFFFF, 1'b0}, // R1 mask A
        '{1'b0, 2'd3, 32'h0,        32'h0,        32'hFFFFFFFF, 1'b0}, // R1 mask B
        '{1'b1, 2'd1, 32'h00001333, 32'h00001000, 32'h00001333, 1'b1}, // R4
        '{1'b1, 2'd1, 32'h00001333, 32'h00000000, 32'h00001000, 1'b0}, // R5
        '{1'b0, 2'd1, 32'h0,        32'h0,        32'h00001000, 1'b0}, // R3/R5
        '{1'b1, 2'd0, 32'hFFFFFFFF, 32'hFFFFFF05, 32'h0000003F, 1'b1}, // R6
        '{1'b0, 2'd0, 32'h0,        32'h0,        32'h00000005, 1'b0}, // R6
        '{1'b1, 2'd2, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'hFFFFFFFF, 1'b1}, // R4 mask A
        '{1'b0, 2'd3, 32'h0,        32'h0,        32'hFFFFFFFF, 1'b0}, // R10
        '{1'b0, 2'd2, 32'h0,        32'h0,        32'hFFFFFFFE, 1'b0}, // R2/R3
        '{1'b1, 2'd1, 32'hFFFF1000, 32'h0000ABCD, 32'h00001000, 1'b1}, // R6
        '{1'b0, 2'd1, 32'h0,        32'h0,        32'h00000BCD, 1'b0}  // R6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, accepted at the next rising edge, response read at the following falling edge
    task automatic xfer(input logic op, input logic [1:0] sel, input logic [31:0] cmp,
                        input logic [31:0] nd, output logic vld, output logic [31:0] old,
                        output logic sw);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_sel = sel; req_cmp = cmp; req_new = nd;
        @(negedge clk);
        req_valid = 1'b0;
        vld = rsp_valid; old = rsp_old; sw = rsp_swapped;
    endtask

    initial begin
        #(20000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic        v, s;
        logic [31:0] o;
        rst = 1'b1; bus_reset = 1'b0; req_valid = 1'b0;
        req_op = 1'b0; req_sel = 2'd0; req_cmp = '0; req_new = '0;
        repeat (3) @(negedge clk);
        check("R7 reset rsp_valid", 32'(rsp_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R8 ready after reset", 32'(req_ready), 32'd1);

        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i].op, VEC[i].sel, VEC[i].cmp, VEC[i].nd, v, o, s);
            check($sformatf("R7 vector %0d valid", i), 32'(v), 32'd1);
            check($sformatf("R2 vector %0d old", i), o, VEC[i].exp_old);
            check($sformatf("R4 vector %0d swapped", i), 32'(s), 32'(VEC[i].exp_sw));
        end

        // R7: idle cycle gives no response
        @(negedge clk);
        check("R7 idle", 32'(rsp_valid), 32'd0);

        // R9: back-to-back swaps on mask B with the same compare value
        @(negedge clk);
        req_valid = 1'b1; req_op = 1'b1; req_sel = 2'd3;
        req_cmp = 32'hFFFFFFFF; req_new = 32'h7FFFFFFF;
        @(negedge clk);
        req_new = 32'h3FFFFFFF;
        check("R9 first valid", 32'(rsp_valid), 32'd1);
        check("R9 first swapped", 32'(rsp_swapped), 32'd1);
        check("R9 first old", rsp_old, 32'hFFFFFFFF);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 second valid", 32'(rsp_valid), 32'd1);
        check("R9 second swapped", 32'(rsp_swapped), 32'd0);
        check("R9 second old", rsp_old, 32'h7FFFFFFF);
        xfer(1'b0, 2'd3, 32'h0, 32'h0, v, o, s);
        check("R9 mask B kept first value", o, 32'h7FFFFFFF);

        // R8: bus reset refuses a request and restores power-on values
        @(negedge clk);
        bus_reset = 1'b1; req_valid = 1'b1; req_op = 1'b1; req_sel = 2'd1;
        req_cmp = 32'h00000BCD; req_new = 32'h00000001;
        #1;
        check("R8 ready low in bus reset", 32'(req_ready), 32'd0);
        @(negedge clk);
        bus_reset = 1'b0; req_valid = 1'b0;
        check("R8 no response to refused request", 32'(rsp_valid), 32'd0);
        xfer(1'b0, 2'd0, 32'h0, 32'h0, v, o, s);
        check("R8 manager restored", o, 32'h0000003F);
        xfer(1'b0, 2'd1, 32'h0, 32'h0, v, o, s);
        check("R8 bandwidth restored", o, 32'h00001333);
        xfer(1'b0, 2'd2, 32'h0, 32'h0, v, o, s);
        check("R8 mask A restored", o, 32'hFFFFFFFF);
        xfer(1'b0, 2'd3, 32'h0, 32'h0, v, o, s);
        check("R8 mask B restored", o, 32'hFFFFFFFF);

        // R5: mismatch on manager register leaves it unchanged
        xfer(1'b1, 2'd0, 32'h00000001, 32'h00000002, v, o, s);
        check("R5 manager mismatch swapped", 32'(s), 32'd0);
        xfer(1'b0, 2'd0, 32'h0, 32'h0, v, o, s);
        check("R5 manager unchanged", o, 32'h0000003F);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule